// File: doc/BRIEF.md
# Multi-mode 16-bit timer

This block is a 16-bit up-counting timer. A single counter core serves eight operating modes chosen by a 3-bit field: one-shot, continuous, counter, PWM, capture, compare, gated and capture/compare. A power-of-two prescaler divides the clock ahead of the counter. The block has one input pin and one output pin. It raises a one-cycle interrupt pulse on reload, capture and gate events.

Software works through a small register port. Writes go through a write strobe, a 2-bit write address and a 16-bit data word. Reads go through a separate combinational read address. Address 0 holds the live count. Address 1 holds the reload (terminal) value. Address 2 holds the PWM match value or the captured count. Address 3 is the control byte: bit 7 enable, bit 6 polarity, bits 5:3 prescale exponent, bits 2:0 mode.

The input pin passes through a two-flop synchronizer before any edge or level decision.

Top module: `tmr16`

## Requirements
- R1: After reset, all four registers read 0, the output pin is 0 and no interrupt is pending.
- R2: In timed modes the count advances once every 2^p enabled cycles, where p is control bits 5:3. The value 3'b111 divides by 128. The prescaler restarts whenever the timer is disabled.
- R3: Reaching the reload value in continuous mode (mode 3'b001) pulses the interrupt and sets the count to 0001h. A written start value therefore affects only the first pass.
- R4: In one-shot mode (3'b000), reaching the reload value pulses the interrupt, sets the count to 0001h and clears the enable bit. After that the count holds.
- R5: Counter mode (3'b010) advances once per synchronized input edge, with no prescaling. Polarity 0 counts rising edges and polarity 1 counts falling edges.
- R6: In PWM mode (3'b011), writing control with enable 0 drives the output to the inverse of polarity. While running, a count equal to the match value drives the output to polarity, and a reload drives it back to the inverse and pulses the interrupt.
- R7: In capture mode (3'b100), an active input edge copies the current count into register 2 and pulses the interrupt in the same cycle. Counting continues.
- R8: In compare mode (3'b101), reaching the reload value pulses the interrupt and toggles the output. The count keeps incrementing past it without a reload.
- R9: In gated mode (3'b110), the count advances only while the input is at its active level (high for polarity 0). The end of the active level pulses the interrupt.
- R10: In capture/compare mode (3'b111), the count holds until the first active input edge, and that edge raises no interrupt. Each later active edge captures the count into register 2, restarts the count at 0001h and pulses the interrupt.
- R11: Outside PWM mode, writing control with enable 0 sets the output to the polarity bit. Each reload event toggles the output.
- R12: Registers are written at the write address and read back at the read address. Count is at 0, reload at 1, match/capture at 2 and control at 3, using the control bit layout given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| tmrIn | input | 1 | Timer input pin (asynchronous) |
| tmrOut | output | 1 | Timer output pin |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situations to reach are those driven by the input pin: the first edge in capture/compare mode that must stay quiet, and exact captured counts. Both depend on the three-cycle path through the synchronizer and edge detector. The stimulus changes the pin a known number of cycles after the enabling write. It then predicts the captured value and the interrupt count from that offset, and checks that the count holds before the first edge and restarts after the second. Gated mode is reached the same way, with a gate window of known length and its closing interrupt checked afterwards.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [2:0] {
    MODE_ONESHOT = 3'd0,
    MODE_CONT    = 3'd1,
    MODE_COUNT   = 3'd2,
    MODE_PWM     = 3'd3,
    MODE_CAPT    = 3'd4,
    MODE_CMP     = 3'd5,
    MODE_GATE    = 3'd6,
    MODE_CAPCMP  = 3'd7
  } tmrMode_e;

  typedef struct packed {
    logic advance;
    logic restart;
    logic capture;
    logic irq;
    logic outToggle;
    logic outLoad;
    logic outVal;
    logic stopEn;
  } tmrStrobe_t;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_VALUE  = 2'd2;
  localparam logic [1:0] ADDR_CTRL   = 2'd3;
endpackage

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tmrIn,
  input  logic             en,
  input  logic             pol,
  input  logic [PRE_W-1:0] pre,
  input  tmrMode_e         mode,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] valueReg,
  output tmrStrobe_t       stb
);
  localparam int PRE_MAX_W = (1 << PRE_W) - 1;

  logic inMeta, inSync, inPrev;
  logic riseEdge, fallEdge, activeEdge, gateActive, gateFall;
  logic [PRE_MAX_W-1:0] preCnt, preMask;
  logic tick, running, ev, atReload, atMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inMeta <= 1'b0;
      inSync <= 1'b0;
      inPrev <= 1'b0;
    end else begin
      inMeta <= tmrIn;
      inSync <= inMeta;
      inPrev <= inSync;
    end
  end

  assign riseEdge   = inSync & ~inPrev;
  assign fallEdge   = ~inSync & inPrev;
  assign activeEdge = pol ? fallEdge : riseEdge;
  assign gateActive = inSync ^ pol;
  assign gateFall   = pol ? riseEdge : fallEdge;

  assign preMask = ~({PRE_MAX_W{1'b1}} << pre);
  assign tick    = en && (preCnt == preMask);

  always_ff @(posedge clk) begin
    if (!rstN || !en || tick) preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !en)                           running <= 1'b0;
    else if (mode == MODE_CAPCMP && activeEdge) running <= 1'b1;
  end

  assign atReload = (count == reloadVal);
  assign atMatch  = (count == valueReg);

  always_comb begin
    case (mode)
      MODE_COUNT:  ev = en && activeEdge;
      MODE_GATE:   ev = tick && gateActive;
      MODE_CAPCMP: ev = tick && running;
      default:     ev = tick;
    endcase
  end

  always_comb begin
    stb = '0;
    if (ev) begin
      if (mode == MODE_CMP) begin
        stb.advance = 1'b1;
        if (atReload) begin
          stb.irq       = 1'b1;
          stb.outToggle = 1'b1;
        end
      end else if (atReload) begin
        stb.restart = 1'b1;
        stb.irq     = 1'b1;
        stb.stopEn  = (mode == MODE_ONESHOT);
        if (mode == MODE_PWM) begin
          stb.outLoad = 1'b1;
          stb.outVal  = ~pol;
        end else begin
          stb.outToggle = 1'b1;
        end
      end else begin
        stb.advance = 1'b1;
        if (mode == MODE_PWM && atMatch) begin
          stb.outLoad = 1'b1;
          stb.outVal  = pol;
        end
      end
    end
    if (en && activeEdge) begin
      if (mode == MODE_CAPT) begin
        stb.capture = 1'b1;
        stb.irq     = 1'b1;
      end else if (mode == MODE_CAPCMP && running) begin
        stb.capture = 1'b1;
        stb.restart = 1'b1;
        stb.irq     = 1'b1;
      end
    end
    if (en && mode == MODE_GATE && gateFall) stb.irq = 1'b1;
  end

  AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && preMask != '0) |=> (!tick || preMask == '0)); // R2
  AST_COUNTER_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (en && mode == MODE_COUNT && !activeEdge) |-> (!stb.advance && !stb.restart)); // R5
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (en && mode == MODE_GATE && !gateActive) |-> (!stb.advance && !stb.restart)); // R9
  AST_FIRST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (en && mode == MODE_CAPCMP && !running) |-> (!stb.irq && !stb.advance)); // R10
endmodule

// File: rtl/tmr16_dp.sv
module tmr16_dp
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  tmrStrobe_t       stb,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] valueReg,
  output logic             en,
  output logic             pol,
  output logic [PRE_W-1:0] pre,
  output tmrMode_e         mode,
  output logic             tmrOut,
  output logic             irq
);
  localparam int CTRL_W = PRE_W + 5;
  localparam int EN_BIT = CTRL_W - 1;
  localparam int POL_BIT = CTRL_W - 2;

  logic [CTRL_W-1:0] ctrlReg;
  logic cntWr, ctrlWr, idleLevel;

  assign cntWr  = wrEn && (wrAddr == ADDR_COUNT);
  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign idleLevel = (wrData[2:0] == MODE_PWM) ? ~wrData[POL_BIT] : wrData[POL_BIT];

  assign en   = ctrlReg[EN_BIT];
  assign pol  = ctrlReg[POL_BIT];
  assign pre  = ctrlReg[PRE_W+2:3];
  assign mode = tmrMode_e'(ctrlReg[2:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      reloadVal <= '0;
      valueReg  <= '0;
      ctrlReg   <= '0;
      tmrOut    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (cntWr)            count <= wrData;
      else if (stb.restart) count <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (stb.advance) count <= count + 1'b1;

      if (wrEn && wrAddr == ADDR_RELOAD) reloadVal <= wrData;

      if (stb.capture)                       valueReg <= count;
      else if (wrEn && wrAddr == ADDR_VALUE) valueReg <= wrData;

      if (ctrlWr)          ctrlReg <= wrData[CTRL_W-1:0];
      else if (stb.stopEn) ctrlReg[EN_BIT] <= 1'b0;

      if (ctrlWr && !wrData[EN_BIT]) tmrOut <= idleLevel;
      else if (stb.outLoad)          tmrOut <= stb.outVal;
      else if (stb.outToggle)        tmrOut <= ~tmrOut;

      irq <= stb.irq;
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_COUNT:  rdData = count;
      ADDR_RELOAD: rdData = reloadVal;
      ADDR_VALUE:  rdData = valueReg;
      default:     rdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlReg};
    endcase
  end

  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (valueReg == $past(count))); // R7
  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.restart && !cntWr) |=> (count == 1)); // R3
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stopEn && !ctrlWr) |=> !en); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !cntWr) |=> (count == $past(count))); // R4
  AST_PWM_MATCH_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PWM && stb.outLoad && !stb.restart && !ctrlWr) |=> (tmrOut == $past(pol))); // R6
endmodule

// File: rtl/tmr16.sv
module tmr16
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic             tmrIn,
  output logic             tmrOut,
  output logic             irq
);
  tmrStrobe_t       stb;
  logic [CNT_W-1:0] count, reloadVal, valueReg;
  logic             en, pol;
  logic [PRE_W-1:0] pre;
  tmrMode_e         mode;

  tmr16_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tmrIn(tmrIn), .en(en), .pol(pol), .pre(pre),
    .mode(mode), .count(count), .reloadVal(reloadVal), .valueReg(valueReg),
    .stb(stb)
  );

  tmr16_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .stb(stb), .count(count),
    .reloadVal(reloadVal), .valueReg(valueReg), .en(en), .pol(pol),
    .pre(pre), .mode(mode), .tmrOut(tmrOut), .irq(irq)
  );
endmodule

// File: tb/tmr16_test.sv
`timescale 1ns/1ps
module tmr16_test;
  localparam real CLK_PERIOD = 5.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic [1:0] rdAddr = 2'd0;
  logic [15:0] rdData;
  logic tmrIn = 1'b0;
  logic tmrOut, irq;

  int checks = 0;
  int errors = 0;
  int irqSeen = 0;
  int irqExp = 0;
  bit done = 0;

  typedef struct {
    int kind;
    logic [1:0] addr;
    logic [15:0] exp;
    string req;
  } item_t;
  item_t sb[$];

  tmr16 uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .tmrIn(tmrIn), .tmrOut(tmrOut), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: counts interrupt pulses and drains the scoreboard
  always @(negedge clk) begin
    item_t it;
    logic [15:0] act;
    if (rstN && irq) irqSeen++;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      case (it.kind)
        0: begin rdAddr = it.addr; #1; act = rdData; end
        1: act = irqSeen[15:0];
        default: act = {15'd0, tmrOut};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic expReg(input logic [1:0] a, input logic [15:0] e, input string req);
    item_t it;
    it.kind = 0; it.addr = a; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic expIrq(input string req);
    item_t it;
    it.kind = 1; it.addr = 2'd0; it.exp = irqExp[15:0]; it.req = req;
    sb.push_back(it);
  endtask

  task automatic expOut(input logic v, input string req);
    item_t it;
    it.kind = 2; it.addr = 2'd0; it.exp = {15'd0, v}; it.req = req;
    sb.push_back(it);
  endtask

  task automatic pulse();
    tmrIn = 1'b1; step(4);
    tmrIn = 1'b0; step(4);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    expReg(2'd0, 16'h0, "R1 count"); expReg(2'd1, 16'h0, "R1 reload");
    step(1);
    expReg(2'd2, 16'h0, "R1 value"); expReg(2'd3, 16'h0, "R1 ctrl");
    expOut(1'b0, "R1 out"); expIrq("R1 irq");
    step(1);

    // R12 register readback
    wr(2'd1, 16'h1234); expReg(2'd1, 16'h1234, "R12 reload");
    wr(2'd2, 16'hBEEF); expReg(2'd2, 16'hBEEF, "R12 value");

    // R3 / R11 continuous
    wr(2'd1, 16'd5); wr(2'd0, 16'd3); wr(2'd3, 16'h0081);
    step(3); irqExp++;
    expReg(2'd0, 16'd1, "R3 first pass"); expIrq("R3 irq"); expOut(1'b1, "R11 toggle");
    step(5); irqExp++;
    expReg(2'd0, 16'd1, "R3 restart 0001"); expIrq("R3 irq2"); expOut(1'b0, "R11 toggle2");
    wr(2'd3, 16'h0000);

    // R4 one-shot
    wr(2'd1, 16'd3); wr(2'd0, 16'd1); wr(2'd3, 16'h0080);
    step(3); irqExp++;
    expReg(2'd3, 16'h0000, "R4 enable cleared"); expReg(2'd0, 16'd1, "R4 count");
    expIrq("R4 irq"); expOut(1'b1, "R11 oneshot toggle");
    step(4);
    expReg(2'd0, 16'd1, "R4 holds"); expIrq("R4 no more irq");
    wr(2'd3, 16'h0000);

    // R2 prescaler
    wr(2'd1, 16'hFFFF); wr(2'd0, 16'd1); wr(2'd3, 16'h0099);
    step(7); expReg(2'd0, 16'd1, "R2 div8 early");
    step(1); expReg(2'd0, 16'd2, "R2 div8 tick");
    step(8); expReg(2'd0, 16'd3, "R2 div8 tick2");
    wr(2'd3, 16'h0000); wr(2'd0, 16'd1); wr(2'd3, 16'h00B9);
    step(127); expReg(2'd0, 16'd1, "R2 div128 early");
    step(1); expReg(2'd0, 16'd2, "R2 div128 tick");
    wr(2'd3, 16'h0000);

    // R5 counter mode, prescale field set but unused
    wr(2'd1, 16'd3); wr(2'd0, 16'd1); wr(2'd3, 16'h00BA);
    pulse(); pulse();
    expReg(2'd0, 16'd3, "R5 rising edges"); expIrq("R5 no irq yet"); expOut(1'b0, "R11 counter idle");
    pulse(); irqExp++;
    expReg(2'd0, 16'd1, "R5 reload"); expIrq("R5 irq"); expOut(1'b1, "R11 counter toggle");
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'd1); wr(2'd3, 16'h00C2);
    tmrIn = 1'b1; step(4); expReg(2'd0, 16'd1, "R5 pol1 ignores rise");
    tmrIn = 1'b0; step(4); expReg(2'd0, 16'd2, "R5 pol1 counts fall");
    wr(2'd3, 16'h0000);

    // R6 PWM
    wr(2'd3, 16'h0003); expOut(1'b1, "R6 idle high");
    wr(2'd1, 16'd10); wr(2'd2, 16'd4); wr(2'd0, 16'd1); wr(2'd3, 16'h0083);
    step(3); expOut(1'b1, "R6 before match"); expReg(2'd0, 16'd4, "R6 count");
    step(1); expOut(1'b0, "R6 match low");
    step(5); expOut(1'b0, "R6 still low"); expReg(2'd0, 16'd10, "R6 at reload");
    step(1); irqExp++;
    expOut(1'b1, "R6 reload high"); expReg(2'd0, 16'd1, "R6 restart"); expIrq("R6 irq");
    wr(2'd3, 16'h0000);

    // R7 capture
    wr(2'd1, 16'hFFFF); wr(2'd0, 16'd1); wr(2'd3, 16'h0084);
    step(10); tmrIn = 1'b1;
    step(3); irqExp++;
    expReg(2'd2, 16'd13, "R7 captured"); expReg(2'd0, 16'd14, "R7 keeps counting");
    expIrq("R7 irq");
    tmrIn = 1'b0; step(4);
    wr(2'd3, 16'h0000);

    // R8 compare
    wr(2'd1, 16'd4); wr(2'd0, 16'd1); wr(2'd3, 16'h0085);
    step(4); irqExp++;
    expReg(2'd0, 16'd5, "R8 no reload"); expOut(1'b1, "R8 toggle"); expIrq("R8 irq");
    wr(2'd3, 16'h0000);

    // R9 gated
    wr(2'd1, 16'hFFFF); wr(2'd0, 16'd1); wr(2'd3, 16'h0086);
    step(10); expReg(2'd0, 16'd1, "R9 gate closed");
    tmrIn = 1'b1; step(10);
    tmrIn = 1'b0; step(20); irqExp++;
    expReg(2'd0, 16'd11, "R9 gate window"); expIrq("R9 gate end irq");
    wr(2'd3, 16'h0000);

    // R10 capture/compare
    wr(2'd0, 16'd1); wr(2'd3, 16'h0087);
    step(5); expReg(2'd0, 16'd1, "R10 waits for edge");
    tmrIn = 1'b1;
    step(3); expReg(2'd0, 16'd1, "R10 start edge"); expIrq("R10 first edge quiet");
    step(1); expReg(2'd0, 16'd2, "R10 counting");
    tmrIn = 1'b0; step(11);
    tmrIn = 1'b1; step(3); irqExp++;
    expReg(2'd2, 16'd15, "R10 captured"); expReg(2'd0, 16'd1, "R10 restart");
    expIrq("R10 irq");
    tmrIn = 1'b0;
    step(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule